// File: doc/BRIEF.md
# Script Engine Run Control Register

This block holds the byte-wide control register of an instruction-fetch engine inside a bus-mastering peripheral and sequences that engine between idle and running. Software, or the engine's own instruction stream, writes the register. The block turns the register contents into a start strobe, a prefetch enable and a prefetch flush request, a single-step interrupt, the cache-line size the bus logic should use, and the drive pair of an active-low interrupt pin.

The engine starts when the start bit is written while the engine is idle. It runs until an interrupt condition appears. In single-step mode it also stops after every completed instruction. The start bit reads back as 1 for as long as the engine runs. A second write of the start bit resumes execution after a step halt. Masking the interrupt pin hides a pending interrupt only at the pin. The condition is kept, so the pin asserts as soon as the mask is removed.

Top module: `srun_ctl_top`

## Requirements
- R1: After reset, every register bit reads 0, the engine is idle, no start, flush or step interrupt is signalled, prefetch is disabled and the interrupt pin is released (irq_oe=0, irq_out=0).
- R2: The register fields sit at these bits: 7 cache-line select, 6 flush, 5 prefetch enable, 4 single-step, 3 pin drive mode, 2 start/running, 1 pin mask, 0 compatibility. Bits 7, 5, 4, 3, 1 and 0 read back as last written.
- R3: Writing 1 to bit 6 raises pf_flush_req and bit 6. Both stay set until a flush_done pulse clears them on the following cycle. If a new flush write coincides with flush_done, the bit stays set.
- R4: pf_enable is 1 exactly when bit 5 is set and burst_len is at least 4.
- R5: Writing bit 2 = 1 while idle makes running and read bit 2 go to 1 in the next cycle. fetch_start is 1 in that cycle only.
- R6: While running, an interrupt condition sampled high stops the engine, and running and bit 2 are 0 in the next cycle.
- R7: With bit 4 set, a completed instruction stops the engine and sets step_irq. step_irq holds until the next start.
- R8: A start write while the engine is running produces no further fetch_start pulse and leaves it running.
- R9: While the engine is running, host writes are ignored, and writes flagged as coming from the engine are accepted.
- R10: With bit 1 set, a pending interrupt (irq_cond or step_irq) does not drive the pin low. Clearing bit 1 while the interrupt is pending drives the pin low in the cycle after the write.
- R11: With bit 3 = 1 the pin is push-pull: irq_oe=1 and irq_out is low exactly when the pin is asserted. With bit 3 = 0 it is open-drain: irq_out=0 and irq_oe=1 exactly when the pin is asserted.
- R12: cls_eff equals cls_mode when bit 7 is 0, and the smaller of cls_mode and cls_cfg when bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_from_engine | input | 1 | Marks the write as issued by the engine's instruction stream |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read-back, bit 2 showing the running state |
| instr_done | input | 1 | One-cycle pulse at the end of each instruction |
| irq_cond | input | 1 | Level interrupt condition from the rest of the chip |
| flush_done | input | 1 | Prefetch unit has finished flushing |
| burst_len | input | BURST_W (4) | Programmed burst length in transfers |
| cls_mode | input | CLS_W (8) | Cache-line size from the mode register |
| cls_cfg | input | CLS_W (8) | Cache-line size from bus configuration space |
| fetch_start | output | 1 | One-cycle pulse when the engine leaves idle |
| running | output | 1 | Engine is running |
| pf_enable | output | 1 | Prefetch unit enable |
| pf_flush_req | output | 1 | Flush request to the prefetch unit |
| step_irq | output | 1 | Single-step interrupt pending |
| cls_eff | output | CLS_W (8) | Effective cache-line size |
| irq_oe | output | 1 | Interrupt pin output enable |
| irq_out | output | 1 | Interrupt pin data, active low |

## Verification
Two pairs of functions can meet in the same cycle. The first is a flush write and the flush completion. The bench drives a write of bit 6 together with a flush_done pulse while a flush is outstanding, and it expects the request still to be set afterwards. It then expects a lone flush_done to clear it. The second pair is a start write and a running engine. The bench repeats the start write, from the host and from the engine, while the engine runs, and it checks that no second start pulse appears and that the host write left the other bits unchanged.

// File: rtl/srun_pkg.sv
package srun_pkg;

    localparam int CTL_W = 8;

    typedef struct packed {
        logic cls_sel;
        logic flush;
        logic pf_en;
        logic step;
        logic drv_pp;
        logic go;
        logic irq_mask;
        logic compat;
    } ctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_st_e;

    function automatic logic [31:0] min_u32(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/srun_ctl_reg.sv
module srun_ctl_reg
    import srun_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_acc,
    input  ctl_t wr_val,
    input  logic flush_done,
    output ctl_t cfg
);

    ctl_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (wr_acc) begin
                cfg_q.cls_sel  <= wr_val.cls_sel;
                cfg_q.pf_en    <= wr_val.pf_en;
                cfg_q.step     <= wr_val.step;
                cfg_q.drv_pp   <= wr_val.drv_pp;
                cfg_q.irq_mask <= wr_val.irq_mask;
                cfg_q.compat   <= wr_val.compat;
            end
            // a new flush write wins over a completion in the same cycle
            if (wr_acc && wr_val.flush) begin
                cfg_q.flush <= 1'b1;
            end else if (flush_done) begin
                cfg_q.flush <= 1'b0;
            end
            cfg_q.go <= 1'b0;
        end
    end

    assign cfg = cfg_q;

    assert_flush_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.flush && flush_done && !(wr_acc && wr_val.flush)) |=> !cfg_q.flush);

    assert_flush_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && wr_val.flush) |=> cfg_q.flush);

endmodule

// File: rtl/srun_run_seq.sv
module srun_run_seq
    import srun_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  logic step_mode,
    input  logic instr_done,
    input  logic irq_cond,
    output logic running,
    output logic fetch_start,
    output logic step_pend
);

    run_st_e st_q, st_d;
    logic    start_q, start_d;
    logic    pend_q, pend_d;
    logic    step_halt;

    assign step_halt = (st_q == ST_RUN) && instr_done && step_mode;

    always_comb begin
        st_d    = st_q;
        start_d = 1'b0;
        pend_d  = pend_q;
        case (st_q)
            ST_IDLE: begin
                if (start_req) begin
                    st_d    = ST_RUN;
                    start_d = 1'b1;
                    pend_d  = 1'b0;
                end
            end
            ST_RUN: begin
                if (step_halt) begin
                    pend_d = 1'b1;
                end
                if (irq_cond || step_halt) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            start_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_q <= start_d;
            pend_q  <= pend_d;
        end
    end

    assign running     = (st_q == ST_RUN);
    assign fetch_start = start_q;
    assign step_pend   = pend_q;

    assert_start_enters_run_R5: assert property (@(posedge clk) disable iff (rst)
        (!running && start_req) |=> (running && fetch_start));

    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        fetch_start |=> !fetch_start);

    assert_irq_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (running && irq_cond) |=> !running);

    assert_step_halt_R7: assert property (@(posedge clk) disable iff (rst)
        (running && instr_done && step_mode) |=> (!running && step_pend));

endmodule

// File: rtl/srun_irq_drv.sv
module srun_irq_drv (
    input  logic pending,
    input  logic mask,
    input  logic push_pull,
    output logic pin_oe,
    output logic pin_out
);

    logic asserted;

    assign asserted = pending && !mask;

    always_comb begin
        if (push_pull) begin
            pin_oe  = 1'b1;
            pin_out = !asserted;
        end else begin
            pin_oe  = asserted;
            pin_out = 1'b0;
        end
    end

endmodule

// File: rtl/srun_cls_pick.sv
module srun_cls_pick
    import srun_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         use_min,
    input  logic [W-1:0] mode_val,
    input  logic [W-1:0] cfg_val,
    output logic [W-1:0] eff
);

    logic [31:0] smaller;

    assign smaller = min_u32(32'(mode_val), 32'(cfg_val));
    assign eff     = use_min ? smaller[W-1:0] : mode_val;

endmodule

// File: rtl/srun_ctl_top.sv
module srun_ctl_top
    import srun_pkg::*;
#(
    parameter int BURST_W      = 4,
    parameter int CLS_W        = 8,
    parameter int PF_MIN_BURST = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_from_engine,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic               instr_done,
    input  logic               irq_cond,
    input  logic               flush_done,
    input  logic [BURST_W-1:0] burst_len,
    input  logic [CLS_W-1:0]   cls_mode,
    input  logic [CLS_W-1:0]   cls_cfg,
    output logic               fetch_start,
    output logic               running,
    output logic               pf_enable,
    output logic               pf_flush_req,
    output logic               step_irq,
    output logic [CLS_W-1:0]   cls_eff,
    output logic               irq_oe,
    output logic               irq_out
);

    localparam logic [BURST_W:0] MIN_BURST = (BURST_W + 1)'(PF_MIN_BURST);

    ctl_t wr_val;
    ctl_t cfg;
    ctl_t view;
    logic wr_acc;
    logic start_req;
    logic run_w;

    assign wr_val    = ctl_t'(wr_data);
    assign wr_acc    = wr_en && (!run_w || wr_from_engine);
    assign start_req = wr_acc && wr_val.go;

    srun_ctl_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .wr_acc     (wr_acc),
        .wr_val     (wr_val),
        .flush_done (flush_done),
        .cfg        (cfg)
    );

    srun_run_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .step_mode   (cfg.step),
        .instr_done  (instr_done),
        .irq_cond    (irq_cond),
        .running     (run_w),
        .fetch_start (fetch_start),
        .step_pend   (step_irq)
    );

    srun_irq_drv u_irq (
        .pending   (irq_cond || step_irq),
        .mask      (cfg.irq_mask),
        .push_pull (cfg.drv_pp),
        .pin_oe    (irq_oe),
        .pin_out   (irq_out)
    );

    srun_cls_pick #(.W(CLS_W)) u_cls (
        .use_min  (cfg.cls_sel),
        .mode_val (cls_mode),
        .cfg_val  (cls_cfg),
        .eff      (cls_eff)
    );

    always_comb begin
        view    = cfg;
        view.go = run_w;
    end

    assign rd_data      = view;
    assign running      = run_w;
    assign pf_flush_req = cfg.flush;
    assign pf_enable    = cfg.pf_en && ({1'b0, burst_len} >= MIN_BURST);

    assert_host_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (run_w && wr_en && !wr_from_engine) |=> ((rd_data & 8'hBB) == ($past(rd_data) & 8'hBB)));

    assert_mask_holds_pin_R10: assert property (@(posedge clk) disable iff (rst)
        rd_data[1] |-> !(irq_oe && !irq_out));

    assert_release_asserts_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !wr_val.irq_mask && (irq_cond || step_irq) && !run_w && !wr_val.go) |=> (irq_oe && !irq_out));

endmodule

// File: tb/srun_ctl_top_bench.sv
module srun_ctl_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_from_engine;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       instr_done, irq_cond, flush_done;
    logic [3:0] burst_len;
    logic [7:0] cls_mode, cls_cfg, cls_eff;
    logic       fetch_start, running, pf_enable, pf_flush_req, step_irq, irq_oe, irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    srun_ctl_top u_srun_ctl_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_from_engine(wr_from_engine),
        .wr_data(wr_data), .rd_data(rd_data), .instr_done(instr_done),
        .irq_cond(irq_cond), .flush_done(flush_done), .burst_len(burst_len),
        .cls_mode(cls_mode), .cls_cfg(cls_cfg), .fetch_start(fetch_start),
        .running(running), .pf_enable(pf_enable), .pf_flush_req(pf_flush_req),
        .step_irq(step_irq), .cls_eff(cls_eff), .irq_oe(irq_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one write cycle; returns at the following negedge with the result visible
    task automatic wr(input logic [7:0] d, input logic eng);
        wr_en = 1'b1; wr_data = d; wr_from_engine = eng;
        @(negedge clk);
        wr_en = 1'b0; wr_from_engine = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 rd_data", rd_data, 0);
        chk("R1 running", running, 0);
        chk("R1 fetch_start", fetch_start, 0);
        chk("R1 flush", pf_flush_req, 0);
        chk("R1 step_irq", step_irq, 0);
        chk("R1 pf_enable", pf_enable, 0);
        chk("R1 pin", {irq_oe, irq_out}, 2'b00);
    endtask

    task automatic t_layout();
        wr(8'hA9, 0);
        chk("R2 readback A9", rd_data, 8'hA9);
        wr(8'h02, 0);
        chk("R2 readback 02", rd_data, 8'h02);
        wr(8'h00, 0);
        chk("R2 readback 00", rd_data, 8'h00);
    endtask

    task automatic t_prefetch();
        burst_len = 4'd3;
        wr(8'h20, 0);
        chk("R4 burst 3", pf_enable, 0);
        burst_len = 4'd4; #1;
        chk("R4 burst 4", pf_enable, 1);
        burst_len = 4'd8; #1;
        chk("R4 burst 8", pf_enable, 1);
        wr(8'h00, 0);
        chk("R4 bit clear", pf_enable, 0);
    endtask

    task automatic t_cls();
        cls_mode = 8'd16; cls_cfg = 8'd8; #1;
        chk("R12 select off", cls_eff, 16);
        wr(8'h80, 0);
        chk("R12 min cfg", cls_eff, 8);
        cls_cfg = 8'd32; #1;
        chk("R12 min mode", cls_eff, 16);
        wr(8'h00, 0);
    endtask

    task automatic t_flush();
        wr(8'h40, 0);
        chk("R3 request", pf_flush_req, 1);
        chk("R3 bit6", rd_data[6], 1);
        wr(8'h00, 0);
        tick();
        chk("R3 held", pf_flush_req, 1);
        flush_done = 1'b1;
        wr(8'h40, 0);
        flush_done = 1'b0;
        chk("R3 collision keeps", pf_flush_req, 1);
        flush_done = 1'b1; tick(); flush_done = 1'b0;
        chk("R3 cleared", pf_flush_req, 0);
        chk("R3 bit6 cleared", rd_data[6], 0);
    endtask

    task automatic t_run();
        wr(8'h04, 0);
        chk("R5 running", running, 1);
        chk("R5 start pulse", fetch_start, 1);
        chk("R5 bit2", rd_data[2], 1);
        tick();
        chk("R5 pulse ends", fetch_start, 0);
        wr(8'h04, 0);
        chk("R8 host restart no pulse", fetch_start, 0);
        wr(8'h04, 1);
        chk("R8 engine restart no pulse", fetch_start, 0);
        chk("R8 still running", running, 1);
        wr(8'h20, 0);
        chk("R9 host write ignored", rd_data, 8'h04);
        wr(8'h24, 1);
        chk("R9 engine write taken", rd_data, 8'h24);
        irq_cond = 1'b1; tick();
        chk("R6 stopped", running, 0);
        chk("R6 bit2", rd_data[2], 0);
        chk("R11 open-drain asserted", {irq_oe, irq_out}, 2'b10);
        irq_cond = 1'b0; #1;
        chk("R11 open-drain released", {irq_oe, irq_out}, 2'b00);
        wr(8'h00, 0);
    endtask

    task automatic t_step();
        wr(8'h10, 0);
        wr(8'h14, 0);
        chk("R7 running", running, 1);
        tick();
        chk("R7 no halt without done", running, 1);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        chk("R7 halted", running, 0);
        chk("R7 step irq", step_irq, 1);
        tick();
        chk("R7 step irq held", step_irq, 1);
        wr(8'h12, 0);
        chk("R10 masked pin", irq_oe, 0);
        chk("R10 pending kept", step_irq, 1);
        wr(8'h10, 0);
        chk("R10 release asserts", {irq_oe, irq_out}, 2'b10);
        wr(8'h18, 0);
        chk("R11 push-pull asserted", {irq_oe, irq_out}, 2'b10);
        wr(8'h1C, 0);
        chk("R7 restart clears", step_irq, 0);
        chk("R7 restart runs", running, 1);
        chk("R11 push-pull idle", {irq_oe, irq_out}, 2'b11);
        instr_done = 1'b1; tick(); instr_done = 1'b0;
        chk("R7 second halt", running, 0);
        chk("R11 push-pull low", {irq_oe, irq_out}, 2'b10);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 0; wr_from_engine = 0; wr_data = 0;
        instr_done = 0; irq_cond = 0; flush_done = 0;
        burst_len = 0; cls_mode = 8'd16; cls_cfg = 8'd8;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        t_reset();
        t_layout();
        t_prefetch();
        t_cls();
        t_flush();
        t_run();
        t_step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule